// File: doc/BRIEF.md
# DMA Channel Run-Control

This block decides when a single DMA channel may own the bus and move data. Software programs a unit count and two permission bits: a channel-enable and a master-enable. While permitted, the block raises a bus request, waits for the grant, and then issues transfer units, one byte or one word each, until the count is used up or permission is withdrawn. Address generation and data movement sit in a neighbouring datapath, which receives the transfer strobe and answers each unit with a done acknowledge.

The channel has two static configuration inputs: full-address mode, and burst versus one-unit-per-grant operation. In burst mode the bus is kept for consecutive units. In the other mode the bus is handed back after every unit. The master-enable only gates the channel in full-address mode. A non-maskable interrupt request, sampled each cycle, withdraws the master-enable, but only for a full-address channel running in burst mode. Whatever causes a stop, the unit already in flight always completes before the bus is released. The remaining count is kept, so setting the cleared bit again resumes the transfer where it stopped.

Top module: `dma_run_ctrl`

## Requirements
- R1: After a synchronous reset, chan_en, mst_en, count, bus_req, xfer_go and xfer_end are all 0.
- R2: With cfg_full_addr=1 the channel requests the bus only when chan_en and mst_en are both 1. With cfg_full_addr=0, chan_en=1 alone is enough and mst_en is ignored.
- R3: When nmi_req is high at a clock edge while cfg_full_addr=1 and cfg_burst=1, mst_en is 0 after that edge.
- R4: When cfg_full_addr=0 or cfg_burst=0, nmi_req leaves mst_en unchanged.
- R5: Once xfer_go is high it stays high until a cycle in which xfer_done is high. A unit in flight is never abandoned.
- R6: bus_req stays high across all units of a burst. It is low in the cycle after the final unit's xfer_done. With cfg_burst=0, bus_req falls after every unit and rises again one cycle later while the channel stays permitted.
- R7: Clearing chan_en, or clearing mst_en when cfg_full_addr=1, stops the channel after the current unit and releases the bus. Setting the bit to 1 again resumes the transfer with no other reprogramming.
- R8: count decrements by exactly one on each unit's xfer_done. It is held across a stop. A count write is accepted only while the channel is idle (bus_req=0) and is ignored otherwise.
- R9: When the unit that takes count from 1 to 0 completes, chan_en is cleared and xfer_end is high for exactly one cycle, in the same cycle that bus_req falls.
- R10: An nmi_req that applies under R3, arriving at the same edge as a write of 1 to mst_en, leaves mst_en at 0.
- R11: A unit starts (xfer_go rises) only in the cycle after bus_gnt was sampled high while bus_req was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_full_addr | input | 1 | 1 = full-address mode (master-enable takes part in gating) |
| cfg_burst | input | 1 | 1 = keep the bus for consecutive units |
| wr_chan_en | input | 1 | CPU write strobe for the channel-enable bit |
| wr_chan_en_val | input | 1 | Value written to the channel-enable bit |
| wr_mst_en | input | 1 | CPU write strobe for the master-enable bit |
| wr_mst_en_val | input | 1 | Value written to the master-enable bit |
| wr_count | input | 1 | CPU write strobe for the unit count |
| wr_count_val | input | CNT_W | Unit count to load |
| nmi_req | input | 1 | Non-maskable interrupt request, sampled each cycle |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| xfer_done | input | 1 | Acknowledge that the current unit finished |
| bus_req | output | 1 | Bus request |
| xfer_go | output | 1 | Unit strobe, held until xfer_done |
| chan_en | output | 1 | Channel-enable bit |
| mst_en | output | 1 | Master-enable bit |
| count | output | CNT_W | Remaining unit count |
| xfer_end | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The run logic is exercised three ways. A slow, predictable responder lets an interrupt land between two acknowledges, which shows whether the unit in flight finishes and the count is kept. A one-unit-per-grant run checks that the bus drops and is re-requested after each unit, not once per burst. A long randomized phase scatters enable writes, count writes, interrupts and configuration changes against an unpredictable grant and acknowledge, and compares every output each cycle with a requirement-level model. Directed cases cover the points the random phase seldom hits: an interrupt in both modes where it must not act, an interrupt colliding with a write of 1, and a count write while busy.

// File: rtl/dmrc_pkg.sv
package dmrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } run_state_e;

    typedef struct packed {
        logic full_addr;
        logic burst;
    } chan_cfg_t;

    // Channel may run: master gating applies only in full-address mode.
    function automatic logic run_permit(input logic ch, input logic ms, input logic full);
        return ch & (ms | ~full);
    endfunction

    // Interrupt withdraws the master bit only for full-address burst channels.
    function automatic logic nmi_applies(input chan_cfg_t c);
        return c.full_addr & c.burst;
    endfunction

endpackage

// File: rtl/dmrc_enable.sv
module dmrc_enable
    import dmrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      wr_chan,
    input  logic      wr_chan_val,
    input  logic      wr_mst,
    input  logic      wr_mst_val,
    input  logic      nmi,
    input  logic      tc_clear,
    output logic      chan_en,
    output logic      mst_en,
    output logic      run_ok_nx
);

    logic chan_nx;
    logic mst_nx;
    logic nmi_hit;

    assign nmi_hit = nmi & nmi_applies(cfg);

    always_comb begin
        // interrupt beats a software write of the master bit
        if (nmi_hit)
            mst_nx = 1'b0;
        else if (wr_mst)
            mst_nx = wr_mst_val;
        else
            mst_nx = mst_en;

        // terminal count beats a software write of the channel bit
        if (tc_clear)
            chan_nx = 1'b0;
        else if (wr_chan)
            chan_nx = wr_chan_val;
        else
            chan_nx = chan_en;
    end

    assign run_ok_nx = run_permit(chan_nx, mst_nx, cfg.full_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_en <= 1'b0;
            mst_en  <= 1'b0;
        end else begin
            chan_en <= chan_nx;
            mst_en  <= mst_nx;
        end
    end

    AST_NMI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (nmi && cfg.full_addr && cfg.burst) |=> !mst_en); // R3
    AST_NMI_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (nmi && !(cfg.full_addr && cfg.burst) && !wr_mst) |=> (mst_en == $past(mst_en))); // R4
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
        (nmi && cfg.full_addr && cfg.burst && wr_mst && wr_mst_val) |=> !mst_en); // R10

endmodule

// File: rtl/dmrc_count.sv
module dmrc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_cnt_val,
    input  logic             unit_done,
    output logic [CNT_W-1:0] count,
    output logic             cnt_nx_nz,
    output logic             last_unit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_nx;

    always_comb begin
        count_nx = count;
        if (idle && wr_cnt)
            count_nx = wr_cnt_val;
        else if (unit_done)
            count_nx = count - ONE;
    end

    assign cnt_nx_nz = (count_nx != '0);
    assign last_unit = (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count_nx;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        unit_done |=> (count == $past(count) - ONE)); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!unit_done && !(idle && wr_cnt)) |=> $stable(count)); // R8

endmodule

// File: rtl/dmrc_seq.sv
module dmrc_seq
    import dmrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic burst,
    input  logic run_ok_nx,
    input  logic cnt_nx_nz,
    input  logic last_unit,
    input  logic bus_gnt,
    input  logic xfer_done,
    output logic bus_req,
    output logic xfer_go,
    output logic idle,
    output logic unit_done,
    output logic tc,
    output logic xfer_end
);

    run_state_e state;
    run_state_e state_nx;

    assign bus_req   = (state != ST_IDLE);
    assign xfer_go   = (state == ST_XFER);
    assign idle      = (state == ST_IDLE);
    assign unit_done = xfer_go & xfer_done;
    assign tc        = unit_done & last_unit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (run_ok_nx && cnt_nx_nz) state_nx = ST_REQ;
            ST_REQ: begin
                if (!run_ok_nx)
                    state_nx = ST_IDLE;
                else if (bus_gnt)
                    state_nx = ST_XFER;
            end
            ST_XFER: begin
                if (xfer_done) begin
                    if (tc)
                        state_nx = ST_IDLE;
                    else if (burst && run_ok_nx)
                        state_nx = ST_XFER;
                    else
                        state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            xfer_end <= 1'b0;
        end else begin
            state    <= state_nx;
            xfer_end <= tc;
        end
    end

    AST_GO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && !xfer_done) |=> xfer_go); // R5
    AST_GO_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_go) |-> $past(bus_gnt && bus_req)); // R11
    AST_GO_UNDER_REQ: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> bus_req); // R6
    AST_STOP_AFTER_UNIT: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && xfer_done && !run_ok_nx) |=> !bus_req); // R7
    AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_end |=> !xfer_end); // R9
    AST_END_RELEASES: assert property (@(posedge clk) disable iff (rst)
        xfer_end |-> !bus_req); // R9

endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
    import dmrc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_full_addr,
    input  logic             cfg_burst,
    input  logic             wr_chan_en,
    input  logic             wr_chan_en_val,
    input  logic             wr_mst_en,
    input  logic             wr_mst_en_val,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] wr_count_val,
    input  logic             nmi_req,
    input  logic             bus_gnt,
    input  logic             xfer_done,
    output logic             bus_req,
    output logic             xfer_go,
    output logic             chan_en,
    output logic             mst_en,
    output logic [CNT_W-1:0] count,
    output logic             xfer_end
);

    chan_cfg_t cfg;
    logic      run_ok_nx;
    logic      cnt_nx_nz;
    logic      last_unit;
    logic      idle;
    logic      unit_done;
    logic      tc;

    assign cfg.full_addr = cfg_full_addr;
    assign cfg.burst     = cfg_burst;

    dmrc_enable u_enable (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .wr_chan    (wr_chan_en),
        .wr_chan_val(wr_chan_en_val),
        .wr_mst     (wr_mst_en),
        .wr_mst_val (wr_mst_en_val),
        .nmi        (nmi_req),
        .tc_clear   (tc),
        .chan_en    (chan_en),
        .mst_en     (mst_en),
        .run_ok_nx  (run_ok_nx)
    );

    dmrc_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .wr_cnt    (wr_count),
        .wr_cnt_val(wr_count_val),
        .unit_done (unit_done),
        .count     (count),
        .cnt_nx_nz (cnt_nx_nz),
        .last_unit (last_unit)
    );

    dmrc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .burst    (cfg.burst),
        .run_ok_nx(run_ok_nx),
        .cnt_nx_nz(cnt_nx_nz),
        .last_unit(last_unit),
        .bus_gnt  (bus_gnt),
        .xfer_done(xfer_done),
        .bus_req  (bus_req),
        .xfer_go  (xfer_go),
        .idle     (idle),
        .unit_done(unit_done),
        .tc       (tc),
        .xfer_end (xfer_end)
    );

    AST_GATED_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> (chan_en && (mst_en || !cfg_full_addr))); // R2
    AST_END_CLEARS_CHAN: assert property (@(posedge clk) disable iff (rst)
        xfer_end |-> !chan_en); // R9

endmodule

// File: tb/dma_run_ctrl_bench.sv
module dma_run_ctrl_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_full_addr = 1'b0, cfg_burst = 1'b0;
    logic          wr_chan_en = 1'b0, wr_chan_en_val = 1'b0;
    logic          wr_mst_en = 1'b0, wr_mst_en_val = 1'b0;
    logic          wr_count = 1'b0;
    logic [CW-1:0] wr_count_val = '0;
    logic          nmi_req = 1'b0;
    logic          bus_gnt = 1'b0, xfer_done = 1'b0;
    logic          bus_req, xfer_go, chan_en, mst_en, xfer_end;
    logic [CW-1:0] count;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit rnd_bus = 1'b0;
    int dly = 0;
    int wait_cnt = 0;

    // requirement-level model state
    int            m_st = 0;  // 0 idle, 1 requesting, 2 unit in flight
    bit            m_chan = 0, m_mst = 0, m_end = 0;
    logic [CW-1:0] m_cnt = '0;

    dma_run_ctrl #(.CNT_W(CW)) u_dma_run_ctrl (
        .clk(clk), .rst(rst),
        .cfg_full_addr(cfg_full_addr), .cfg_burst(cfg_burst),
        .wr_chan_en(wr_chan_en), .wr_chan_en_val(wr_chan_en_val),
        .wr_mst_en(wr_mst_en), .wr_mst_en_val(wr_mst_en_val),
        .wr_count(wr_count), .wr_count_val(wr_count_val),
        .nmi_req(nmi_req), .bus_gnt(bus_gnt), .xfer_done(xfer_done),
        .bus_req(bus_req), .xfer_go(xfer_go), .chan_en(chan_en),
        .mst_en(mst_en), .count(count), .xfer_end(xfer_end)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        wr_chan_en = 1'b0;
        wr_mst_en  = 1'b0;
        wr_count   = 1'b0;
        nmi_req    = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // model next-state from the requirements
    function automatic bit m_ok(input bit ch, input bit ms, input bit full);
        return ch && (ms || !full);
    endfunction

    always @(negedge clk) begin
        bit hit, tc, n_mst, n_chan, ok;
        logic [CW-1:0] n_cnt;
        int n_st;
        if (rst) begin
            m_st = 0; m_chan = 0; m_mst = 0; m_end = 0; m_cnt = '0;
            bus_gnt = 0; xfer_done = 0; wait_cnt = 0;
        end else begin
            chk("R6 bus_req", 32'(bus_req), 32'(m_st != 0));
            chk("R11 xfer_go", 32'(xfer_go), 32'(m_st == 2));
            chk("R7 chan_en", 32'(chan_en), 32'(m_chan));
            chk("R3 mst_en", 32'(mst_en), 32'(m_mst));
            chk("R8 count", 32'(count), 32'(m_cnt));
            chk("R9 xfer_end", 32'(xfer_end), 32'(m_end));
            // bus and datapath responder
            if (rnd_bus) begin
                bus_gnt   = bus_req && ($urandom % 3 != 0);
                xfer_done = xfer_go && ($urandom % 2 == 1);
            end else begin
                bus_gnt = bus_req;
                if (xfer_go) begin
                    if (wait_cnt >= dly) begin xfer_done = 1; wait_cnt = 0; end
                    else begin xfer_done = 0; wait_cnt++; end
                end else begin
                    xfer_done = 0; wait_cnt = 0;
                end
            end
            hit    = nmi_req && cfg_full_addr && cfg_burst;
            tc     = (m_st == 2) && xfer_done && (m_cnt == 1);
            n_mst  = hit ? 1'b0 : (wr_mst_en ? wr_mst_en_val : m_mst);
            n_chan = tc ? 1'b0 : (wr_chan_en ? wr_chan_en_val : m_chan);
            ok     = m_ok(n_chan, n_mst, cfg_full_addr);
            n_cnt  = m_cnt;
            if (m_st == 0 && wr_count) n_cnt = wr_count_val;
            else if (m_st == 2 && xfer_done) n_cnt = m_cnt - 1;
            n_st = m_st;
            case (m_st)
                0: n_st = (ok && n_cnt != 0) ? 1 : 0;
                1: n_st = !ok ? 0 : (bus_gnt ? 2 : 1);
                default: n_st = !xfer_done ? 2 : (tc ? 0 : ((cfg_burst && ok) ? 2 : 0));
            endcase
            m_st = n_st; m_chan = n_chan; m_mst = n_mst; m_cnt = n_cnt; m_end = tc;
        end
    end

    initial begin
        int falls;
        bit prev;
        void'($urandom(32'h5EED_2024));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // reset state
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 xfer_go", 32'(xfer_go), 0);
        chk("R1 chan_en", 32'(chan_en), 0);
        chk("R1 mst_en", 32'(mst_en), 0);
        chk("R1 count", 32'(count), 0);
        chk("R1 xfer_end", 32'(xfer_end), 0);

        // full-address burst: channel bit alone must not start
        cfg_full_addr = 1; cfg_burst = 1; dly = 1;
        wr_count = 1; wr_count_val = 5; wr_chan_en = 1; wr_chan_en_val = 1;
        cyc();
        repeat (5) cyc();
        chk("R2 no request without master", 32'(bus_req), 0);
        chk("R8 count loaded", 32'(count), 5);

        // start, then interrupt between acknowledges
        wr_mst_en = 1; wr_mst_en_val = 1;
        cyc();
        for (int i = 0; i < 100 && count != 3; i++) cyc();
        nmi_req = 1;
        cyc();
        chk("R3 master cleared by interrupt", 32'(mst_en), 0);
        chk("R5 unit still in flight", 32'(xfer_go), 1);
        cyc();
        chk("R7 bus released after unit", 32'(bus_req), 0);
        chk("R8 count kept", 32'(count), 2);
        repeat (4) cyc();
        chk("R7 stays stopped", 32'(bus_req), 0);
        chk("R7 channel bit kept", 32'(chan_en), 1);

        // resume by master bit only
        wr_mst_en = 1; wr_mst_en_val = 1;
        cyc();
        for (int i = 0; i < 100 && !xfer_end; i++) cyc();
        chk("R9 end pulse", 32'(xfer_end), 1);
        chk("R9 channel bit cleared", 32'(chan_en), 0);
        chk("R8 count exhausted", 32'(count), 0);
        chk("R9 bus dropped with end", 32'(bus_req), 0);
        cyc();
        chk("R9 end is one cycle", 32'(xfer_end), 0);

        // interrupt outside full-address burst
        cfg_full_addr = 1; cfg_burst = 0; nmi_req = 1;
        cyc();
        chk("R4 non-burst ignores interrupt", 32'(mst_en), 1);
        cfg_full_addr = 0; cfg_burst = 1; nmi_req = 1;
        cyc();
        chk("R4 short-address ignores interrupt", 32'(mst_en), 1);

        // interrupt against a write of 1
        cfg_full_addr = 1; cfg_burst = 1;
        wr_mst_en = 1; wr_mst_en_val = 0;
        cyc();
        wr_mst_en = 1; wr_mst_en_val = 1; nmi_req = 1;
        cyc();
        chk("R10 interrupt wins over write", 32'(mst_en), 0);

        // one unit per grant, master bit irrelevant outside full-address
        cfg_full_addr = 0; cfg_burst = 0; dly = 0;
        wr_count = 1; wr_count_val = 3; wr_chan_en = 1; wr_chan_en_val = 1;
        cyc();
        falls = 0; prev = bus_req;
        for (int i = 0; i < 200 && !xfer_end; i++) begin
            cyc();
            if (prev && !bus_req) falls++;
            prev = bus_req;
        end
        chk("R2 ran with master bit 0", 32'(xfer_end), 1);
        chk("R6 bus released per unit", 32'(falls), 3);

        // count write while busy, stop by channel bit, resume
        cfg_burst = 1; dly = 3;
        wr_count = 1; wr_count_val = 4; wr_chan_en = 1; wr_chan_en_val = 1;
        cyc();
        for (int i = 0; i < 50 && !xfer_go; i++) cyc();
        wr_count = 1; wr_count_val = 9;
        cyc();
        chk("R8 busy count write ignored", 32'(count), 4);
        wr_chan_en = 1; wr_chan_en_val = 0;
        cyc();
        for (int i = 0; i < 50 && bus_req; i++) cyc();
        chk("R7 stopped by channel bit", 32'(count), 3);
        wr_chan_en = 1; wr_chan_en_val = 1;
        cyc();
        for (int i = 0; i < 100 && !xfer_end; i++) cyc();
        chk("R7 resumed to end", 32'(count), 0);

        // randomized phase
        rnd_bus = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 40 == 0) begin wr_chan_en = 1; wr_chan_en_val = ($urandom % 4 != 0); end
            if ($urandom % 40 == 0) begin wr_mst_en = 1; wr_mst_en_val = ($urandom % 4 != 0); end
            if ($urandom % 25 == 0) nmi_req = 1;
            if ($urandom % 30 == 0) begin wr_count = 1; wr_count_val = CW'($urandom % 6); end
            if ($urandom % 200 == 0) begin
                cfg_full_addr = $urandom % 2;
                cfg_burst = $urandom % 2;
            end
            cyc();
        end
        rnd_bus = 0;
        repeat (2) cyc();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule